// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block sequences the transfers of a single DMA channel. Software loads a working source address, a working destination address and a transfer count, plus a backup copy of each, and a control word. After that the sequencer issues one transfer unit at a time to a bus-master stub. It moves both addresses by the unit size and lowers the count after each unit. The block does not move data, arbitrate between channels or choose the request source. It only decides when a unit may start and what the registers hold after the unit completes.

Each unit is offered on a valid/ready handshake. `xfer_valid` rises with the unit's addresses and size. Once raised, `xfer_valid` and the offered address and count values stay fixed until the stub raises `xfer_ready`. The stub may hold `xfer_ready` low for as long as it needs. One unit completes in each cycle where both are high. A request may come from an internal auto-request or from an external request pin. Three end-of-count behaviours are available: normal, repeat and reload. Half-end and end flags drive maskable interrupt lines. An NMI or address-error indication stops further units, as does clearing either enable.

Top module: `dma_chan_seq`

## Requirements
- R1: A new unit is offered only if all of the following hold: control bit 0 (channel enable) is 1, `master_en` is 1, and the NMI and address-error flags are 0. The end flag must also be 0, except in the case described in R2.
- R2: In repeat mode (control bits 7:6 = 1), a unit is still offered while the end flag is 1, provided control bit 2 (half interrupt enable) is 1 and the half flag is 0.
- R3: Each completed unit lowers the working count by one.
- R4: Each completed unit steps each address by its mode: control bits 9:8 for the source and 11:10 for the destination, where 1 means increment, 2 means decrement, and 0 or 3 means fixed. The step size is 1, 2, 4 or 16 bytes for control bits 13:12 = 0, 1, 2, 3.
- R5: In reload mode (bits 7:6 = 2), the low 16 bits of the backup count act as a sub-counter that drops by one per unit. When it reaches 0, both addresses are taken from their backups and the sub-counter is reloaded from the upper 16 bits of the backup count.
- R6: Outside reload mode, when a unit leaves the count equal to half the backup count (rounded down), the half flag (`flags` bit 1) is set. `irq_half` is high while that flag and control bit 2 are both 1.
- R7: When a unit leaves the count at 0, the end flag (`flags` bit 0) is set. `irq_end` is high while that flag and control bit 1 are both 1.
- R8: In repeat mode, when the count reaches 0 and no stop condition holds, the count is reloaded from the backup count and both addresses from their backups.
- R9: A pulse on `nmi_in` sets `flags` bit 3. A pulse on `addr_err_in` sets `flags` bit 2. Either flag stops new units until software clears it. Clearing either enable also stops new units and blocks the repeat reload.
- R10: When control bit 3 is 1, a request is always present. Otherwise the request pin is level-sensed. The exception is when both bit 4 (edge request) and bit 5 (burst) are 1: then a rising edge latches a pending request, which is consumed when a unit is offered. An edge that arrives while a unit is in flight is kept and served afterwards.
- R11: `xfer_valid`, `xfer_src`, `xfer_dst` and `cur_count` hold while `xfer_valid` is 1 and `xfer_ready` is 0. Writes to the working source, destination or count are ignored while `xfer_valid` is 1.
- R12: In burst mode the next unit may be offered two cycles after a handshake. In cycle-steal mode (bit 5 = 0), `STEAL_GAP` further idle cycles are inserted.
- R13: Register write codes on `cfg_sel` are: 0 source, 1 destination, 2 count, 3 backup source, 4 backup destination, 5 backup count, 6 control, 7 flag clear. A flag-clear write zeroes each flag whose bit in `cfg_wdata[3:0]` is 1; a flag being set in the same cycle takes priority. After reset all registers and flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select (R13) |
| cfg_wdata | input | AW | Write data |
| master_en | input | 1 | Controller-wide enable |
| dreq | input | 1 | External transfer request |
| addr_err_in | input | 1 | Address-error pulse |
| nmi_in | input | 1 | NMI pulse |
| xfer_valid | output | 1 | Unit offered to the bus stub |
| xfer_ready | input | 1 | Bus stub completes the offered unit |
| xfer_src | output | AW | Working source address |
| xfer_dst | output | AW | Working destination address |
| xfer_size | output | 2 | Unit size code |
| cur_count | output | CNT_W | Working transfer count |
| flags | output | 4 | {nmi, addr_err, half, end} |
| irq_end | output | 1 | End interrupt request |
| irq_half | output | 1 | Half-end interrupt request |

## Verification
A behavioural model in the bench tracks every output cycle by cycle. It is driven with the following patterns:
- An auto-requested normal run with a slow stub. This separates count, step and flag timing from handshake stalls.
- A repeat run with the half flag cleared by hand. This tells the reload from the half-flag continuation rule.
- A reload run with a two-unit sub-counter. This shows the address wrap apart from the end of count.
- Level, edge-in-burst and edge-without-burst requests. These separate the three detection modes, including an edge that lands while a unit is stalled.
- NMI, address-error and enable-drop pulses mid-run, and writes made while a unit is offered. These confirm that each of them stops or is ignored exactly as required.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

  localparam logic [1:0] XM_NORMAL = 2'd0;
  localparam logic [1:0] XM_REPEAT = 2'd1;
  localparam logic [1:0] XM_RELOAD = 2'd2;

  localparam logic [1:0] AM_INC = 2'd1;
  localparam logic [1:0] AM_DEC = 2'd2;

  localparam logic [2:0] SEL_SRC  = 3'd0;
  localparam logic [2:0] SEL_DST  = 3'd1;
  localparam logic [2:0] SEL_CNT  = 3'd2;
  localparam logic [2:0] SEL_BSRC = 3'd3;
  localparam logic [2:0] SEL_BDST = 3'd4;
  localparam logic [2:0] SEL_BCNT = 3'd5;
  localparam logic [2:0] SEL_CTRL = 3'd6;
  localparam logic [2:0] SEL_STAT = 3'd7;

  typedef struct packed {
    logic [1:0] usize;
    logic [1:0] dst_am;
    logic [1:0] src_am;
    logic [1:0] xmode;
    logic       burst;
    logic       edge_req;
    logic       auto_req;
    logic       half_ie;
    logic       end_ie;
    logic       chan_en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_GAP = 2'd2} seq_state_e;

  function automatic logic [4:0] unit_bytes(input logic [1:0] sz);
    case (sz)
      2'd0:    return 5'd1;
      2'd1:    return 5'd2;
      2'd2:    return 5'd4;
      default: return 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/dma_req_detect.sv
module dma_req_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic dreq,
  input  logic auto_req,
  input  logic edge_req,
  input  logic burst,
  input  logic unit_launch,
  output logic req
);
  logic dreq_q;
  logic pend_q;
  logic edge_mode;
  logic rise;

  assign edge_mode = edge_req & burst;
  assign rise      = dreq & ~dreq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dreq_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      dreq_q <= dreq;
      pend_q <= edge_mode ? (rise | (pend_q & ~unit_launch)) : 1'b0;
    end
  end

  always_comb begin
    if (auto_req)       req = 1'b1;
    else if (edge_mode) req = pend_q;
    else                req = dreq;
  end

  // R10
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && rise) |=> pend_q);

endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg
  import dma_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  input  logic          step_en,
  input  logic [1:0]    am,
  input  logic [1:0]    usize,
  input  logic          load_en,
  input  logic [AW-1:0] load_val,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] step_amt;
  logic [AW-1:0] stepped;

  assign step_amt = AW'(unit_bytes(usize));

  always_comb begin
    case (am)
      AM_INC:  stepped = addr + step_amt;
      AM_DEC:  stepped = addr - step_amt;
      default: stepped = addr;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (wr_en)   addr <= wr_data;
    else if (load_en) addr <= load_val;
    else if (step_en) addr <= stepped;
  end

  // R4
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en && !wr_en && am == AM_DEC) |=> addr == $past(addr) - $past(step_amt));

endmodule

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit
  import dma_seq_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int SUB_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_we,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic               bcnt_we,
  input  logic [2*SUB_W-1:0] bcnt_wdata,
  input  logic               unit_done,
  input  logic [1:0]         xmode,
  input  logic               rpt_ok,
  output logic [CNT_W-1:0]   cnt_q,
  output logic               hit_zero,
  output logic               hit_half,
  output logic               sub_wrap
);
  localparam int BW = 2 * SUB_W;

  logic [BW-1:0]    bcnt_q;
  logic [CNT_W-1:0] cnt_n;
  logic [CNT_W-1:0] half_mark;
  logic [SUB_W-1:0] sub_q;
  logic [SUB_W-1:0] sub_hi;
  logic             reload_md;

  assign sub_q     = bcnt_q[SUB_W-1:0];
  assign sub_hi    = bcnt_q[BW-1:SUB_W];
  assign cnt_n     = cnt_q - 1'b1;
  assign half_mark = bcnt_q[CNT_W-1:0] >> 1;
  assign reload_md = (xmode == XM_RELOAD);

  assign hit_zero = unit_done & (cnt_n == '0);
  assign hit_half = unit_done & ~reload_md & (cnt_n == half_mark);
  assign sub_wrap = unit_done & reload_md & (sub_q == SUB_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (cnt_we)             cnt_q <= cnt_wdata;
    else if (unit_done) begin
      if (hit_zero && rpt_ok)    cnt_q <= bcnt_q[CNT_W-1:0];
      else                       cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bcnt_q <= '0;
    else if (bcnt_we)            bcnt_q <= bcnt_wdata;
    else if (unit_done && reload_md) begin
      if (sub_wrap)              bcnt_q[SUB_W-1:0] <= sub_hi;
      else                       bcnt_q[SUB_W-1:0] <= sub_q - 1'b1;
    end
  end

  // R3
  count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !cnt_we && cnt_q != CNT_W'(1)) |=> cnt_q == $past(cnt_q) - 1'b1);

  // R8
  repeat_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && !cnt_we && cnt_q == CNT_W'(1) && rpt_ok) |=> cnt_q == $past(bcnt_q[CNT_W-1:0]));

  // R5
  sub_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_done && reload_md && !bcnt_we && sub_q == SUB_W'(1)) |=> bcnt_q[SUB_W-1:0] == $past(sub_hi));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW        = 32,
  parameter int CNT_W     = 24,
  parameter int SUB_W     = 16,
  parameter int STEAL_GAP = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_sel,
  input  logic [AW-1:0]    cfg_wdata,
  input  logic             master_en,
  input  logic             dreq,
  input  logic             addr_err_in,
  input  logic             nmi_in,
  output logic             xfer_valid,
  input  logic             xfer_ready,
  output logic [AW-1:0]    xfer_src,
  output logic [AW-1:0]    xfer_dst,
  output logic [1:0]       xfer_size,
  output logic [CNT_W-1:0] cur_count,
  output logic [3:0]       flags,
  output logic             irq_end,
  output logic             irq_half
);
  localparam int BW = 2 * SUB_W;
  localparam int GW = (STEAL_GAP > 1) ? $clog2(STEAL_GAP) : 1;

  ctrl_t          ctrl_q;
  seq_state_e     st_q;
  logic [GW-1:0]  gap_q;
  logic [AW-1:0]  bsrc_q, bdst_q;
  logic           te_q, he_q, ae_q, nmi_q;
  logic [3:0]     clr;
  logic           hs, launch, req, start_ok, abort, rpt_ok;
  logic           hit_zero, hit_half, sub_wrap, addr_load;
  logic           wr_src, wr_dst, wr_cnt, wr_bcnt;

  assign xfer_valid = (st_q == ST_BUSY);
  assign hs         = xfer_valid & xfer_ready;
  assign xfer_size  = ctrl_q.usize;
  assign flags      = {nmi_q, ae_q, he_q, te_q};
  assign irq_end    = te_q & ctrl_q.end_ie;
  assign irq_half   = he_q & ctrl_q.half_ie;

  assign wr_src  = cfg_we & (cfg_sel == SEL_SRC) & ~xfer_valid;
  assign wr_dst  = cfg_we & (cfg_sel == SEL_DST) & ~xfer_valid;
  assign wr_cnt  = cfg_we & (cfg_sel == SEL_CNT) & ~xfer_valid;
  assign wr_bcnt = cfg_we & (cfg_sel == SEL_BCNT);
  assign clr     = (cfg_we && cfg_sel == SEL_STAT) ? cfg_wdata[3:0] : 4'd0;

  assign abort    = ae_q | nmi_q | ~ctrl_q.chan_en | ~master_en;
  assign rpt_ok   = (ctrl_q.xmode == XM_REPEAT) & ~abort;
  assign start_ok = ctrl_q.chan_en & master_en & ~ae_q & ~nmi_q &
                    (~te_q | ((ctrl_q.xmode == XM_REPEAT) & ctrl_q.half_ie & ~he_q));
  assign launch   = (st_q == ST_IDLE) & start_ok & req;
  assign addr_load = (hit_zero & rpt_ok) | sub_wrap;

  dma_req_detect u_req (
    .clk         (clk),
    .rst_n       (rst_n),
    .dreq        (dreq),
    .auto_req    (ctrl_q.auto_req),
    .edge_req    (ctrl_q.edge_req),
    .burst       (ctrl_q.burst),
    .unit_launch (launch),
    .req         (req)
  );

  dma_addr_reg #(.AW(AW)) u_src (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_src), .wr_data (cfg_wdata),
    .step_en (hs), .am (ctrl_q.src_am), .usize (ctrl_q.usize),
    .load_en (addr_load), .load_val (bsrc_q),
    .addr (xfer_src)
  );

  dma_addr_reg #(.AW(AW)) u_dst (
    .clk (clk), .rst_n (rst_n),
    .wr_en (wr_dst), .wr_data (cfg_wdata),
    .step_en (hs), .am (ctrl_q.dst_am), .usize (ctrl_q.usize),
    .load_en (addr_load), .load_val (bdst_q),
    .addr (xfer_dst)
  );

  dma_cnt_unit #(.CNT_W(CNT_W), .SUB_W(SUB_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_we     (wr_cnt),
    .cnt_wdata  (cfg_wdata[CNT_W-1:0]),
    .bcnt_we    (wr_bcnt),
    .bcnt_wdata (cfg_wdata[BW-1:0]),
    .unit_done  (hs),
    .xmode      (ctrl_q.xmode),
    .rpt_ok     (rpt_ok),
    .cnt_q      (cur_count),
    .hit_zero   (hit_zero),
    .hit_half   (hit_half),
    .sub_wrap   (sub_wrap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      bsrc_q <= '0;
      bdst_q <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_BSRC: bsrc_q <= cfg_wdata;
        SEL_BDST: bdst_q <= cfg_wdata;
        SEL_CTRL: ctrl_q <= ctrl_t'(cfg_wdata[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q  <= 1'b0;
      he_q  <= 1'b0;
      ae_q  <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      te_q  <= (te_q  & ~clr[0]) | hit_zero;
      he_q  <= (he_q  & ~clr[1]) | hit_half;
      ae_q  <= (ae_q  & ~clr[2]) | addr_err_in;
      nmi_q <= (nmi_q & ~clr[3]) | nmi_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      gap_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (launch) st_q <= ST_BUSY;
        ST_BUSY: if (hs) begin
          if (ctrl_q.burst) st_q <= ST_IDLE;
          else begin
            st_q  <= ST_GAP;
            gap_q <= GW'(STEAL_GAP - 1);
          end
        end
        ST_GAP: begin
          if (gap_q == '0) st_q <= ST_IDLE;
          else             gap_q <= gap_q - 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> xfer_valid && $stable(xfer_src) && $stable(xfer_dst) && $stable(cur_count));

  // R1
  start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer_valid) |-> $past(start_ok));

  // R12
  steal_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hs && !ctrl_q.burst) |=> !xfer_valid ##1 !xfer_valid);

  // R7
  end_flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(te_q) |-> $past(hs));

  // R9
  nmi_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_q |-> !launch);

endmodule

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
  localparam int AW = 32;
  localparam int CW = 24;
  localparam int GAP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_sel = 3'd0;
  logic [AW-1:0] cfg_wdata = '0;
  logic master_en = 1'b1;
  logic dreq = 1'b0;
  logic addr_err_in = 1'b0;
  logic nmi_in = 1'b0;
  logic xfer_ready = 1'b0;
  logic xfer_valid, irq_end, irq_half;
  logic [AW-1:0] xfer_src, xfer_dst;
  logic [1:0] xfer_size;
  logic [CW-1:0] cur_count;
  logic [3:0] flags;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rdy_pat = 0;

  always #2 clk = ~clk;

  dma_chan_seq u_dut (
    .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
    .cfg_wdata (cfg_wdata), .master_en (master_en), .dreq (dreq),
    .addr_err_in (addr_err_in), .nmi_in (nmi_in), .xfer_valid (xfer_valid),
    .xfer_ready (xfer_ready), .xfer_src (xfer_src), .xfer_dst (xfer_dst),
    .xfer_size (xfer_size), .cur_count (cur_count), .flags (flags),
    .irq_end (irq_end), .irq_half (irq_half)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_src, m_dst, m_bsrc, m_bdst, m_bcnt;
  logic [23:0] m_cnt;
  logic [13:0] m_ctrl;
  bit m_te, m_he, m_ae, m_nmi, m_pend, m_dq;
  int m_st, m_gap;

  function automatic logic [31:0] mstep(input logic [31:0] a, input logic [1:0] am, input logic [1:0] sz);
    int b;
    b = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 16;
    if (am == 2'd1) return a + b;
    if (am == 2'd2) return a - b;
    return a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_dst = 0; m_bsrc = 0; m_bdst = 0; m_bcnt = 0; m_cnt = 0; m_ctrl = 0;
      m_te = 0; m_he = 0; m_ae = 0; m_nmi = 0; m_pend = 0; m_dq = 0; m_st = 0; m_gap = 0;
    end else begin
      automatic bit hs = (m_st == 1) && xfer_ready;
      automatic bit edge_m = m_ctrl[4] && m_ctrl[5];
      automatic bit rq = m_ctrl[3] ? 1'b1 : (edge_m ? m_pend : dreq);
      automatic int mode = m_ctrl[7:6];
      automatic bit ok = m_ctrl[0] && master_en && !m_ae && !m_nmi &&
                         (!m_te || (mode == 1 && m_ctrl[2] && !m_he));
      automatic bit abrt = m_ae || m_nmi || !m_ctrl[0] || !master_en;
      automatic bit launch = (m_st == 0) && ok && rq;
      automatic bit z = 0, h = 0;
      automatic logic [3:0] clr = 0;
      automatic logic [31:0] n_src = m_src, n_dst = m_dst, n_bcnt = m_bcnt;
      automatic logic [23:0] n_cnt = m_cnt;
      automatic logic [13:0] n_ctrl = m_ctrl;
      if (hs) begin
        n_cnt = m_cnt - 1;
        n_src = mstep(m_src, m_ctrl[9:8], m_ctrl[13:12]);
        n_dst = mstep(m_dst, m_ctrl[11:10], m_ctrl[13:12]);
        if (mode == 2) begin
          if (m_bcnt[15:0] == 1) begin
            n_src = m_bsrc; n_dst = m_bdst; n_bcnt[15:0] = m_bcnt[31:16];
          end else n_bcnt[15:0] = m_bcnt[15:0] - 1;
        end
        if (n_cnt == 0) begin
          z = 1;
          if (mode == 1 && !abrt) begin
            n_cnt = m_bcnt[23:0]; n_src = m_bsrc; n_dst = m_bdst;
          end
        end
        if (mode != 2 && (m_cnt - 24'd1) == (m_bcnt[23:0] >> 1)) h = 1;
      end
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: if (m_st != 1) n_src = cfg_wdata;
          3'd1: if (m_st != 1) n_dst = cfg_wdata;
          3'd2: if (m_st != 1) n_cnt = cfg_wdata[23:0];
          3'd3: m_bsrc = cfg_wdata;
          3'd4: m_bdst = cfg_wdata;
          3'd5: n_bcnt = cfg_wdata;
          3'd6: n_ctrl = cfg_wdata[13:0];
          default: clr = cfg_wdata[3:0];
        endcase
      end
      m_te  = (m_te  && !clr[0]) || z;
      m_he  = (m_he  && !clr[1]) || h;
      m_ae  = (m_ae  && !clr[2]) || addr_err_in;
      m_nmi = (m_nmi && !clr[3]) || nmi_in;
      m_pend = edge_m ? ((dreq && !m_dq) || (m_pend && !launch)) : 1'b0;
      m_dq = dreq;
      case (m_st)
        0: if (launch) m_st = 1;
        1: if (hs) begin
             if (m_ctrl[5]) m_st = 0;
             else begin m_st = 2; m_gap = GAP - 1; end
           end
        default: if (m_gap == 0) m_st = 0; else m_gap = m_gap - 1;
      endcase
      m_src = n_src; m_dst = n_dst; m_cnt = n_cnt; m_bcnt = n_bcnt; m_ctrl = n_ctrl;
    end
  end

  task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare();
    bit ev = (m_st == 1);
    checks++;
    if (xfer_valid !== ev) begin errors++; $display("FAIL R1/R10/R12 valid: actual %h expected %h", xfer_valid, ev); end
    if (xfer_src !== m_src) begin errors++; $display("FAIL R4/R5/R8 src: actual %h expected %h", xfer_src, m_src); end
    if (xfer_dst !== m_dst) begin errors++; $display("FAIL R4/R5/R8 dst: actual %h expected %h", xfer_dst, m_dst); end
    if (cur_count !== m_cnt) begin errors++; $display("FAIL R3/R8 count: actual %h expected %h", cur_count, m_cnt); end
    if (flags !== {m_nmi, m_ae, m_he, m_te}) begin errors++; $display("FAIL R6/R7/R9 flags: actual %h expected %h", flags, {m_nmi, m_ae, m_he, m_te}); end
    if (irq_end !== (m_te && m_ctrl[1])) begin errors++; $display("FAIL R7 irq_end: actual %h expected %h", irq_end, m_te && m_ctrl[1]); end
    if (irq_half !== (m_he && m_ctrl[2])) begin errors++; $display("FAIL R6 irq_half: actual %h expected %h", irq_half, m_he && m_ctrl[2]); end
    if (xfer_size !== m_ctrl[13:12]) begin errors++; $display("FAIL R4 size: actual %h expected %h", xfer_size, m_ctrl[13:12]); end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    compare();
    cyc++;
    xfer_ready = (rdy_pat == 0) ? 1'b1 : (rdy_pat == 1) ? (cyc % 3 == 0) : 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 400 && !flags[0]; i++) step();
  endtask

  task automatic quiesce();
    wr(3'd6, 32'h0);
    rdy_pat = 0;
    for (int i = 0; i < 20 && xfer_valid; i++) step();
    run(4);
    wr(3'd7, 32'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    // R13 reset state
    chk(flags == 4'h0 && !xfer_valid && cur_count == 0 && xfer_src == 0, "R13 reset", {flags, cur_count[3:0]}, 0);

    // Normal, auto, burst, src inc / dst dec, 4-byte units, slow stub
    rdy_pat = 1;
    wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd2, 4); wr(3'd5, 4);
    wr(3'd6, 32'h292F);
    wait_end();
    run(3);
    chk(xfer_src == 32'h1010, "R4 src inc", xfer_src, 32'h1010);
    chk(xfer_dst == 32'h1FF0, "R4 dst dec", xfer_dst, 32'h1FF0);
    chk(cur_count == 0, "R3 count", cur_count, 0);
    chk(flags == 4'h3 && irq_end && irq_half, "R6 R7 flags and irqs", {irq_end, irq_half, flags}, 6'h33);
    wr(3'd7, 32'h1);
    chk(flags == 4'h2, "R13 clear end only", flags, 2);

    // Repeat mode, half continuation
    quiesce();
    wr(3'd0, 32'h100); wr(3'd1, 32'h200); wr(3'd3, 32'h100); wr(3'd4, 32'h200);
    wr(3'd2, 4); wr(3'd5, 4);
    wr(3'd6, 32'h056F);
    wait_end();
    run(12);
    chk(cur_count == 4 && xfer_src == 32'h100, "R8 repeat reload", cur_count, 4);
    chk(!xfer_valid, "R2 blocked with half set", xfer_valid, 0);
    wr(3'd7, 32'h2);
    run(30);
    chk(cur_count == 2 && xfer_src == 32'h102 && flags[0], "R2 resume while end set", cur_count, 2);

    // Reload mode with two-unit sub-counter
    quiesce();
    wr(3'd0, 32'h40); wr(3'd1, 32'h80); wr(3'd3, 32'h40); wr(3'd4, 32'h80);
    wr(3'd2, 5); wr(3'd5, 32'h0002_0002);
    rdy_pat = 1;
    wr(3'd6, 32'h15AF);
    wait_end();
    run(3);
    chk(xfer_src == 32'h42 && xfer_dst == 32'h82, "R5 reload addresses", xfer_src, 32'h42);
    chk(flags == 4'h1, "R5 no half in reload", flags, 1);

    // Level request, cycle-steal, fixed src, inc dst, 16-byte units
    quiesce();
    wr(3'd0, 32'h700); wr(3'd1, 32'h0); wr(3'd2, 3); wr(3'd5, 3);
    wr(3'd6, 32'h3403);
    run(6);
    chk(!xfer_valid && cur_count == 3, "R10 level low no request", cur_count, 3);
    dreq = 1'b1;
    wait_end();
    dreq = 1'b0;
    run(3);
    chk(xfer_dst == 32'h30 && xfer_src == 32'h700, "R4 R12 steal run", xfer_dst, 32'h30);

    // Edge request in burst with an edge during a stalled unit
    quiesce();
    wr(3'd2, 4); wr(3'd5, 4);
    wr(3'd6, 32'h0533);
    rdy_pat = 2;
    dreq = 1'b1; step(); dreq = 1'b0; run(3);
    dreq = 1'b1; step(); dreq = 1'b0; step();
    rdy_pat = 0;
    run(15);
    chk(cur_count == 2, "R10 pending edge served once", cur_count, 2);

    // Edge bit without burst behaves as level
    quiesce();
    wr(3'd2, 3); wr(3'd5, 3);
    wr(3'd6, 32'h0513);
    dreq = 1'b1;
    wait_end();
    dreq = 1'b0;
    chk(flags[0] && cur_count == 0, "R10 edge without burst is level", cur_count, 0);

    // Stop conditions
    quiesce();
    wr(3'd2, 20); wr(3'd5, 20);
    rdy_pat = 1;
    wr(3'd6, 32'h052B);
    run(10);
    nmi_in = 1'b1; step(); nmi_in = 1'b0;
    run(10);
    c0 = cur_count;
    run(10);
    chk(cur_count == c0 && flags[3], "R9 nmi stop", cur_count, c0);
    wr(3'd7, 32'h8);
    run(8);
    chk(cur_count < c0, "R1 resume after clear", cur_count, c0);
    addr_err_in = 1'b1; step(); addr_err_in = 1'b0;
    run(10);
    c0 = cur_count;
    run(10);
    chk(cur_count == c0 && flags[2], "R9 address error stop", cur_count, c0);
    wr(3'd7, 32'h4);
    master_en = 1'b0;
    run(10);
    c0 = cur_count;
    run(10);
    chk(cur_count == c0 && !xfer_valid, "R1 master enable low", cur_count, c0);
    master_en = 1'b1;

    // Channel enable off, writes while a unit is offered
    quiesce();
    wr(3'd0, 32'h500); wr(3'd2, 5); wr(3'd5, 5);
    wr(3'd6, 32'h0028);
    run(5);
    chk(!xfer_valid, "R1 channel enable off", xfer_valid, 0);
    rdy_pat = 2;
    wr(3'd6, 32'h0029);
    run(3);
    chk(xfer_valid, "R11 unit offered", xfer_valid, 1);
    wr(3'd0, 32'h999);
    wr(3'd2, 77);
    chk(xfer_src == 32'h500 && cur_count == 5, "R11 writes ignored while valid", xfer_src, 32'h500);
    run(4);
    chk(xfer_valid && xfer_src == 32'h500, "R11 held under back-pressure", xfer_src, 32'h500);
    quiesce();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule